// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block is the byte-wide configuration register file of a host-bridge function. A configuration agent reaches it through a request channel that carries a read/write flag, an 8-bit index and a write byte. Reads come back as single bytes on a separate response channel. The block holds fixed identity bytes: a revision byte, a three-byte class code that marks the function as a host bridge, and a cache-line-size byte that stays zero. It also holds two writable registers, a bus latency timer and a bridge control byte, and a pair of status bytes. In the status bytes, one bit always reports fast back-to-back capability and another latches a data-parity event.

The data-parity bit sets only when three conditions hold in the same cycle: the bus parity-error line is active, this function mastered the cycle, and parity-error response is enabled. Software clears the bit by writing a one to it. The writable fields drive plain decoded outputs, so the bus master and the slave logic nearby can use them without decoding anything themselves.

Both channels use valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high. A response transfers on a cycle where `rsp_valid` and `rsp_ready` are both high. The block holds one response. While that response waits, `req_ready` stays low, so the request side feels back-pressure from the response side.

Top module: `host_cfg_space`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, `lat_timer` is 0, every control output is 0 and `dpd_status` is 0.
- R2: An accepted read produces exactly one response, with `rsp_valid` high on the cycle after acceptance. An accepted write produces no response. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is 0 and `rsp_data` holds its value.
- R3: `dpd_status` becomes 1 on the cycle after `perr_active`, `bus_master_cycle` and `perr_resp_en` are all high together. It never sets when any one of them is low.
- R4: Index 07h reads {7'b0, dpd_status}. A write to 07h with bit 0 = 1 clears the bit. A write to 07h with bit 0 = 0 leaves it unchanged. If a parity event and a clearing write fall in the same cycle, the bit stays 1.
- R5: Index 06h always reads 80h (fast back-to-back capable), and writes to it are ignored.
- R6: Index 08h reads the revision parameter (default 00h). Indexes 09h, 0Ah and 0Bh read the class code bytes, low byte first (default 00h, 00h, 06h). Writes to these indexes are ignored.
- R7: Index 0Ch (cache line size) always reads 00h, and writes to it are ignored.
- R8: Index 0Dh holds the latency timer. Bits 4:0 are read/write and drive `lat_timer`. Bits 7:5 read 0.
- R9: Index 40h holds the control byte. Bits 6..1 are read/write and drive, in that order, `ctl_single_write`, `ctl_single_read`, `ctl_retry_busy`, `ctl_slv_wbuf_en`, `ctl_line_read_en` and `ctl_burst_en`. Bits 7 and 0 read 0.
- R10: Index 0Eh..3Fh and every other unlisted index reads 00h. Writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 8 | Configuration byte index |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read byte |
| perr_active | input | 1 | Bus parity-error line asserted or observed |
| bus_master_cycle | input | 1 | This function mastered the current bus cycle |
| perr_resp_en | input | 1 | Parity-error response enable from the command register |
| dpd_status | output | 1 | Latched data-parity-detected bit |
| lat_timer | output | 5 | Latency timer field |
| ctl_single_write | output | 1 | Slave disconnects after one write data phase |
| ctl_single_read | output | 1 | Slave disconnects after one read data phase |
| ctl_retry_busy | output | 1 | Retry while master write buffers hold data |
| ctl_slv_wbuf_en | output | 1 | Slave write buffers enabled |
| ctl_line_read_en | output | 1 | Inbound reads fetch a full cache line |
| ctl_burst_en | output | 1 | Burst on internal bus for invalidate writes |

## Verification
The assertions check the following on every cycle. The parity bit rises only after all three qualifiers were high. It falls only after an accepted clearing write that had no coincident event. A held response keeps its data. A response appears only after an accepted read. The timer and control outputs move only after an accepted write to their own index. The bench scenarios cover what needs concrete values. They read back every index, including masked and reserved bits. They check that writes to read-only and unmapped indexes are ignored, and that a parity event beats a same-cycle clear. They also hold the response back to show that the request side stalls.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;
  // Index decodes the neighbours rely on
  localparam logic [7:0] IX_STAT_LO = 8'h06;
  localparam logic [7:0] IX_STAT_HI = 8'h07;
  localparam logic [7:0] IX_REV     = 8'h08;
  localparam logic [7:0] IX_CLS_0   = 8'h09;
  localparam logic [7:0] IX_CLS_1   = 8'h0A;
  localparam logic [7:0] IX_CLS_2   = 8'h0B;
  localparam logic [7:0] IX_LINE    = 8'h0C;
  localparam logic [7:0] IX_LAT     = 8'h0D;
  localparam logic [7:0] IX_CTL     = 8'h40;

  localparam int DPD_BIT  = 0;  // bit of the high status byte
  localparam int FBB_BIT  = 7;  // bit of the low status byte
  localparam logic [7:0] CTL_MASK = 8'h7E;

  typedef struct packed {
    logic       single_write;
    logic       single_read;
    logic       retry_busy;
    logic       slv_wbuf_en;
    logic       line_read_en;
    logic       burst_en;
  } ctl_fields_t;
endpackage

// File: rtl/hcfg_req_port.sv
module hcfg_req_port #(
  parameter int IDX_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_index,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  input  logic [DW-1:0]    rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_index,
  output logic [DW-1:0]    wr_data
);
  logic fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_en     = fire && req_write;
  assign wr_index  = req_index;
  assign wr_data   = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hcfg_parity_status.sv
module hcfg_parity_status (
  input  logic clk,
  input  logic rst_n,
  input  logic perr_active,
  input  logic bus_master_cycle,
  input  logic perr_resp_en,
  input  logic clr_req,
  output logic dpd
);
  logic set_evt;

  assign set_evt = perr_active && bus_master_cycle && perr_resp_en;

  // A set event outranks a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n)       dpd <= 1'b0;
    else if (set_evt) dpd <= 1'b1;
    else if (clr_req) dpd <= 1'b0;
  end
endmodule

// File: rtl/hcfg_regs.sv
module hcfg_regs
  import hcfg_pkg::*;
#(
  parameter int          IDX_W      = 8,
  parameter int          LAT_W      = 5,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h060000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_index,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_index,
  input  logic             dpd,
  output logic [7:0]       rd_data,
  output logic [LAT_W-1:0] lat_q,
  output ctl_fields_t      ctl_q
);
  localparam int CLS_BYTES = 3;
  localparam logic [7:0] LAT_MASK = 8'((1 << LAT_W) - 1);

  logic [7:0] ctl_byte;
  logic [7:0] cls_byte [CLS_BYTES];

  for (genvar b = 0; b < CLS_BYTES; b++) begin : g_cls
    assign cls_byte[b] = CLASS_CODE[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q    <= '0;
      ctl_byte <= '0;
    end else if (wr_en) begin
      if (wr_index == IDX_W'(IX_LAT)) lat_q    <= wr_data[LAT_W-1:0];
      if (wr_index == IDX_W'(IX_CTL)) ctl_byte <= wr_data & CTL_MASK;
    end
  end

  assign ctl_q = ctl_fields_t'(ctl_byte[6:1]);

  always_comb begin
    rd_data = 8'h00;
    unique case (rd_index)
      IDX_W'(IX_STAT_LO): rd_data[FBB_BIT] = 1'b1;
      IDX_W'(IX_STAT_HI): rd_data[DPD_BIT] = dpd;
      IDX_W'(IX_REV):     rd_data = REV_ID;
      IDX_W'(IX_CLS_0):   rd_data = cls_byte[0];
      IDX_W'(IX_CLS_1):   rd_data = cls_byte[1];
      IDX_W'(IX_CLS_2):   rd_data = cls_byte[2];
      IDX_W'(IX_LINE):    rd_data = 8'h00;
      IDX_W'(IX_LAT):     rd_data = 8'(lat_q) & LAT_MASK;
      IDX_W'(IX_CTL):     rd_data = ctl_byte;
      default:            rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/host_cfg_space.sv
module host_cfg_space
  import hcfg_pkg::*;
#(
  parameter int          IDX_W      = 8,
  parameter int          LAT_W      = 5,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h060000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_index,
  input  logic [7:0]       req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  input  logic             perr_active,
  input  logic             bus_master_cycle,
  input  logic             perr_resp_en,
  output logic             dpd_status,
  output logic [LAT_W-1:0] lat_timer,
  output logic             ctl_single_write,
  output logic             ctl_single_read,
  output logic             ctl_retry_busy,
  output logic             ctl_slv_wbuf_en,
  output logic             ctl_line_read_en,
  output logic             ctl_burst_en
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_index;
  logic [7:0]       wr_data;
  logic [7:0]       rd_data;
  logic             clr_req;
  ctl_fields_t      ctl_q;

  hcfg_req_port #(.IDX_W(IDX_W), .DW(8)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_index (req_index),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_index  (wr_index),
    .wr_data   (wr_data)
  );

  assign clr_req = wr_en && (wr_index == IDX_W'(IX_STAT_HI)) && wr_data[DPD_BIT];

  hcfg_parity_status u_stat (
    .clk              (clk),
    .rst_n            (rst_n),
    .perr_active      (perr_active),
    .bus_master_cycle (bus_master_cycle),
    .perr_resp_en     (perr_resp_en),
    .clr_req          (clr_req),
    .dpd              (dpd_status)
  );

  hcfg_regs #(
    .IDX_W(IDX_W), .LAT_W(LAT_W), .REV_ID(REV_ID), .CLASS_CODE(CLASS_CODE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_index (wr_index),
    .wr_data  (wr_data),
    .rd_index (req_index),
    .dpd      (dpd_status),
    .rd_data  (rd_data),
    .lat_q    (lat_timer),
    .ctl_q    (ctl_q)
  );

  assign ctl_single_write = ctl_q.single_write;
  assign ctl_single_read  = ctl_q.single_read;
  assign ctl_retry_busy   = ctl_q.retry_busy;
  assign ctl_slv_wbuf_en  = ctl_q.slv_wbuf_en;
  assign ctl_line_read_en = ctl_q.line_read_en;
  assign ctl_burst_en     = ctl_q.burst_en;
endmodule

// File: rtl/host_cfg_space_chk.sv
module host_cfg_space_chk #(
  parameter int IDX_W = 8,
  parameter int LAT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [IDX_W-1:0] req_index,
  input logic [7:0]       req_wdata,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_data,
  input logic             perr_active,
  input logic             bus_master_cycle,
  input logic             perr_resp_en,
  input logic             dpd_status,
  input logic [LAT_W-1:0] lat_timer,
  input logic             ctl_single_write,
  input logic             ctl_single_read,
  input logic             ctl_retry_busy,
  input logic             ctl_slv_wbuf_en,
  input logic             ctl_line_read_en,
  input logic             ctl_burst_en
);
  logic       acc_wr;
  logic       acc_rd;
  logic       evt;
  logic [5:0] ctl_vec;

  assign acc_wr  = req_valid && req_ready && req_write;
  assign acc_rd  = req_valid && req_ready && !req_write;
  assign evt     = perr_active && bus_master_cycle && perr_resp_en;
  assign ctl_vec = {ctl_single_write, ctl_single_read, ctl_retry_busy,
                    ctl_slv_wbuf_en, ctl_line_read_en, ctl_burst_en};

  assert_dpd_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dpd_status) |-> $past(evt));

  assert_dpd_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> dpd_status);

  assert_dpd_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dpd_status) |-> $past(acc_wr && req_index == IDX_W'(8'h07) && req_wdata[0] && !evt));

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_rsp_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(acc_rd));

  assert_lat_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lat_timer) |-> $past(acc_wr && req_index == IDX_W'(8'h0D)));

  assert_ctl_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_vec) |-> $past(acc_wr && req_index == IDX_W'(8'h40)));
endmodule

bind host_cfg_space host_cfg_space_chk #(.IDX_W(IDX_W), .LAT_W(LAT_W)) u_chk (.*);

// File: tb/tb_host_cfg_space.sv
module tb_host_cfg_space;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_index = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       perr_active = 1'b0;
  logic       bus_master_cycle = 1'b0;
  logic       perr_resp_en = 1'b0;
  logic       dpd_status;
  logic [4:0] lat_timer;
  logic       ctl_single_write, ctl_single_read, ctl_retry_busy;
  logic       ctl_slv_wbuf_en, ctl_line_read_en, ctl_burst_en;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  host_cfg_space dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: each response transfer is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected response", 32'(rsp_data), 32'hDEAD);
      end else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(rsp_data), 32'(e));
      end
    end
  end

  task automatic send(input logic wr, input logic [7:0] idx, input logic [7:0] wd);
    logic acc;
    req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = wd;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk);
    end while (!acc);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    send(1'b0, idx, 8'h00);
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [7:0] wd);
    send(1'b1, idx, wd);
  endtask

  task automatic pulse(input logic p, input logic m, input logic e);
    perr_active = p; bus_master_cycle = m; perr_resp_en = e;
    @(posedge clk); #1;
    perr_active = 0; bus_master_cycle = 0; perr_resp_en = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 req_ready", 32'(req_ready), 1);
    check("R1 lat_timer", 32'(lat_timer), 0);
    check("R1 ctl", 32'({ctl_single_write, ctl_single_read, ctl_retry_busy,
                         ctl_slv_wbuf_en, ctl_line_read_en, ctl_burst_en}), 0);
    check("R1 dpd", 32'(dpd_status), 0);
    @(posedge clk); #1;

    do_read(8'h06, 8'h80, "R5 status low");
    do_read(8'h07, 8'h00, "R4 status high idle");
    do_read(8'h08, 8'h00, "R6 revision");
    do_read(8'h09, 8'h00, "R6 class byte0");
    do_read(8'h0A, 8'h00, "R6 class byte1");
    do_read(8'h0B, 8'h06, "R6 class byte2");
    do_read(8'h0C, 8'h00, "R7 line size");
    do_read(8'h0D, 8'h00, "R8 lat reset");
    do_read(8'h40, 8'h00, "R9 ctl reset");

    // R8 latency timer masking
    do_write(8'h0D, 8'hFF);
    @(negedge clk); check("R2 no write response", 32'(rsp_valid), 0);
    check("R8 lat out", 32'(lat_timer), 32'h1F);
    @(posedge clk); #1;
    do_read(8'h0D, 8'h1F, "R8 lat readback");
    do_write(8'h0D, 8'hA5);
    do_read(8'h0D, 8'h05, "R8 lat readback2");

    // R9 control fields
    do_write(8'h40, 8'hFF);
    do_read(8'h40, 8'h7E, "R9 ctl all ones");
    @(negedge clk);
    check("R9 ctl outs all", 32'({ctl_single_write, ctl_single_read, ctl_retry_busy,
                                  ctl_slv_wbuf_en, ctl_line_read_en, ctl_burst_en}), 32'h3F);
    @(posedge clk); #1;
    do_write(8'h40, 8'h55);
    do_read(8'h40, 8'h54, "R9 ctl pattern");
    @(negedge clk);
    check("R9 single_write", 32'(ctl_single_write), 1);
    check("R9 single_read",  32'(ctl_single_read), 0);
    check("R9 retry_busy",   32'(ctl_retry_busy), 1);
    check("R9 slv_wbuf_en",  32'(ctl_slv_wbuf_en), 0);
    check("R9 line_read_en", 32'(ctl_line_read_en), 1);
    check("R9 burst_en",     32'(ctl_burst_en), 0);
    @(posedge clk); #1;

    // Read-only indexes ignore writes
    do_write(8'h06, 8'h00);
    do_write(8'h08, 8'hFF);
    do_write(8'h09, 8'hFF);
    do_write(8'h0B, 8'hFF);
    do_write(8'h0C, 8'hFF);
    do_read(8'h06, 8'h80, "R5 status low after write");
    do_read(8'h08, 8'h00, "R6 revision after write");
    do_read(8'h09, 8'h00, "R6 class0 after write");
    do_read(8'h0B, 8'h06, "R6 class2 after write");
    do_read(8'h0C, 8'h00, "R7 line after write");

    // R10 unmapped indexes
    do_write(8'h0E, 8'hFF);
    do_write(8'h3F, 8'hFF);
    do_write(8'h80, 8'hFF);
    do_read(8'h0E, 8'h00, "R10 idx 0E");
    do_read(8'h3F, 8'h00, "R10 idx 3F");
    do_read(8'h80, 8'h00, "R10 idx 80");
    do_read(8'hFF, 8'h00, "R10 idx FF");
    do_read(8'h0D, 8'h05, "R10 lat untouched");
    do_read(8'h40, 8'h54, "R10 ctl untouched");
    @(negedge clk);
    check("R10 lat out", 32'(lat_timer), 32'h05);
    check("R10 ctl outs", 32'({ctl_single_write, ctl_single_read, ctl_retry_busy,
                               ctl_slv_wbuf_en, ctl_line_read_en, ctl_burst_en}), 32'h2A);
    @(posedge clk); #1;

    // R3 partial qualifiers do not set
    pulse(1, 1, 0);
    pulse(1, 0, 1);
    pulse(0, 1, 1);
    @(negedge clk); check("R3 no set partial", 32'(dpd_status), 0);
    @(posedge clk); #1;
    pulse(1, 1, 1);
    @(negedge clk); check("R3 set on all three", 32'(dpd_status), 1);
    @(posedge clk); #1;
    do_read(8'h07, 8'h01, "R4 status high set");

    // R4 write-one-to-clear
    do_write(8'h07, 8'h00);
    do_write(8'h07, 8'hFE);
    @(negedge clk); check("R4 zero write keeps", 32'(dpd_status), 1);
    @(posedge clk); #1;
    do_write(8'h07, 8'h01);
    @(negedge clk); check("R4 one write clears", 32'(dpd_status), 0);
    @(posedge clk); #1;
    do_read(8'h07, 8'h00, "R4 status high cleared");
    pulse(1, 1, 1);
    perr_active = 1; bus_master_cycle = 1; perr_resp_en = 1;
    do_write(8'h07, 8'h01);
    perr_active = 0; bus_master_cycle = 0; perr_resp_en = 0;
    @(negedge clk); check("R4 set beats clear", 32'(dpd_status), 1);
    @(posedge clk); #1;
    do_write(8'h07, 8'hFF);
    @(negedge clk); check("R4 clear after race", 32'(dpd_status), 0);
    @(posedge clk); #1;

    // R2 back-pressure
    rsp_ready = 1'b0;
    do_read(8'h0B, 8'h06, "R2 held response");
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 stall req_ready", 32'(req_ready), 0);
    check("R2 stall rsp_valid", 32'(rsp_valid), 1);
    check("R2 stall rsp_data", 32'(rsp_data), 32'h06);
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    do_read(8'h06, 8'h80, "R2 after release");
    repeat (4) @(posedge clk);
    check("R2 scoreboard drained", 32'(exp_q.size()), 0);
    summary();
  end
endmodule